// File: doc/BRIEF.md
# Digital Input Glitch Filter with Selectable Width

This block cleans up a single asynchronous digital input, such as an external trigger or a general-purpose I/O line, before internal timing logic uses it. The input first passes through a two-flop synchronizer. A filter then accepts a new level only after that level has been seen on a set number of consecutive samples. Any sample that agrees with the current output clears the pending count, so glitches shorter than the window never reach the output.

A two-bit setting selects the mode:

- **Off:** the output follows the synchronized input.
- **Fast preset:** samples on every clock with a short count.
- **Medium preset:** samples on every clock with a long count.
- **Slow preset:** samples only on a prescaler tick, which gives a long window with coarse jitter.

A bypass input is used when a line is routed straight between external terminal groups. It forwards the raw input and ignores the filter result.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, the output is 0 with bypass low.
- R2: With setting 0 (off), the output equals the input delayed by exactly three clock edges: two synchronizer stages and one output register.
- R3: With setting 1, the output takes a new level on the clock edge that takes the FAST_CNT-th consecutive synchronized sample differing from the output (default 5).
- R4: A run of differing samples shorter than the count leaves the output unchanged. The next agreeing sample restarts the count from zero.
- R5: Falling transitions follow the same rule as rising ones: the same number of consecutive low samples is needed.
- R6: With setting 2, the required run is MID_CNT consecutive per-clock samples (default 257).
- R7: With setting 3, samples are taken only on a prescaler tick every SLOW_DIV clocks, and SLOW_CNT consecutive differing ticks are needed (defaults 400 and 256). The prescaler restarts at zero on any setting change, and its first tick comes SLOW_DIV edges later.
- R8: On the edge where the setting differs from its previous value, the count clears and the output holds. The new criterion applies from the next edge.
- R9: While bypass is 1, the output equals the raw input combinationally, whatever the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Asynchronous input terminal |
| setting | input | 2 | 0 off, 1 fast, 2 medium, 3 slow |
| bypass | input | 1 | 1 forwards raw din to dout |
| dout | output | 1 | Filtered or bypassed output |

## Verification
The hardest situation to reach is a setting change that lands mid-count in the slow mode. Here the prescaler phase, the pending count and the held output all interact. The bench reaches it by changing the setting at random run boundaries while driving din with random run lengths that straddle each count. A behavioural model restates the sampling rule with a history queue and integers, and it is compared on every clock. With small override parameters, long windows and prescaler wraps occur many times within the run.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic [1:0] {
    GF_OFF  = 2'd0,
    GF_FAST = 2'd1,
    GF_MID  = 2'd2,
    GF_SLOW = 2'd3
  } gf_mode_e;

  // consecutive-sample requirement for a given setting (0 when off)
  function automatic int unsigned gf_limit(logic [1:0] mode, int unsigned n_fast,
                                           int unsigned n_mid, int unsigned n_slow);
    case (mode)
      GF_FAST: return n_fast;
      GF_MID:  return n_mid;
      GF_SLOW: return n_slow;
      default: return 0;
    endcase
  endfunction

  // counter width able to hold the largest count
  function automatic int unsigned gf_cnt_width(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1);
  endfunction
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gf_tick.sv
module gf_tick #(
  parameter int unsigned DIV = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= '0;
    else if (clr)          phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/gf_core.sv
module gf_core #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chg,
  input  logic          off,
  input  logic          step,
  input  logic          smp,
  input  logic [CW-1:0] last_idx,
  output logic          level,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (chg) begin
      cnt <= '0;
    end else if (off) begin
      level <= smp;
      cnt   <= '0;
    end else if (step) begin
      if (smp == level) begin
        cnt <= '0;
      end else if (cnt == last_idx) begin
        level <= smp;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FAST_CNT    = 5,
  parameter int unsigned MID_CNT     = 257,
  parameter int unsigned SLOW_CNT    = 256,
  parameter int unsigned SLOW_DIV    = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] setting,
  input  logic       bypass,
  output logic       dout
);
  import gf_pkg::*;

  localparam int unsigned CW = gf_cnt_width(FAST_CNT, MID_CNT, SLOW_CNT);

  logic          smp;
  logic          tick;
  logic          step;
  logic          set_chg;
  logic          mode_off;
  logic [1:0]    setting_q;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] cnt;
  logic          level;

  gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(smp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setting_q <= 2'd0;
    else        setting_q <= setting;
  end

  assign set_chg  = (setting != setting_q);
  assign mode_off = (setting == GF_OFF);
  assign last_idx = CW'(gf_limit(setting, FAST_CNT, MID_CNT, SLOW_CNT) - 1);

  gf_tick #(.DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(set_chg), .tick(tick)
  );

  assign step = (setting == GF_SLOW) ? tick : 1'b1;

  gf_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .chg(set_chg), .off(mode_off), .step(step),
    .smp(smp), .last_idx(last_idx), .level(level), .cnt(cnt)
  );

  assign dout = bypass ? din : level;
endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk #(
  parameter int unsigned CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          din,
  input logic [1:0]    setting,
  input logic          bypass,
  input logic          dout,
  input logic          smp,
  input logic          step,
  input logic          set_chg,
  input logic          level,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] last_idx
);
  // R9: bypass forwards the raw input
  a_r9_bypass_raw: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (dout == din));

  // R8: setting change holds the output
  a_r8_hold_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    set_chg |=> $stable(level));

  // R2: off mode registers the synchronized sample
  a_r2_off_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_chg && setting == 2'd0) |=> (level == $past(smp)));

  // R3, R4: filtered output moves only on a full count
  a_r3_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_chg && setting != 2'd0 && !(step && cnt == last_idx)) |=> $stable(level));

  // R7: count frozen between prescaler ticks
  a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_chg && setting != 2'd0 && !step) |=> $stable(cnt));
endmodule

bind glitch_filter glitch_filter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .setting(setting), .bypass(bypass),
  .dout(dout), .smp(smp), .step(step), .set_chg(set_chg), .level(level),
  .cnt(cnt), .last_idx(last_idx)
);

// File: tb/glitch_filter_tb.sv
module glitch_filter_tb;
  localparam int N_FAST = 5;
  localparam int N_MID  = 9;
  localparam int N_SLOW = 4;
  localparam int DIV    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic [1:0] setting = 2'd0;
  logic       bypass = 1'b0;
  logic       dout;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  glitch_filter #(
    .FAST_CNT(N_FAST), .MID_CNT(N_MID), .SLOW_CNT(N_SLOW), .SLOW_DIV(DIV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .setting(setting),
    .bypass(bypass), .dout(dout)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit hist[$];
  int m_level, m_cnt, m_presc, m_prev;

  function automatic int need(int s);
    if (s == 1) return N_FAST;
    if (s == 2) return N_MID;
    return N_SLOW;
  endfunction

  always @(posedge clk) begin
    bit s;
    bit tk;
    if (!rst_n) begin
      hist = {1'b0, 1'b0};
      m_level = 0; m_cnt = 0; m_presc = 0; m_prev = 0;
    end else begin
      s = hist.pop_front();
      hist.push_back(din);
      tk = (m_presc == DIV - 1);
      if (int'(setting) != m_prev) begin
        m_cnt = 0;
        m_presc = 0;
      end else begin
        m_presc = tk ? 0 : m_presc + 1;
        if (setting == 2'd0) begin
          m_level = s;
          m_cnt = 0;
        end else if (setting != 2'd3 || tk) begin
          if (int'(s) == m_level) m_cnt = 0;
          else if (m_cnt + 1 == need(setting)) begin
            m_level = s;
            m_cnt = 0;
          end else m_cnt++;
        end
      end
      m_prev = setting;
    end
    #2;
    if (cmp_on) check(dout == (bypass ? din : m_level[0]), cur_req, dout,
                      bypass ? din : m_level);
  end

  task automatic hold(bit v, int n);
    din = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic runs(int cycles, int maxlen);
    int done = 0;
    while (done < cycles) begin
      int len = 1 + ($urandom % maxlen);
      hold(~din, len);
      done += len;
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(dout == 1'b0, "R1 during reset", dout, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check(dout == 1'b0, "R1 after reset", dout, 0);

    cur_req = "R2";
    for (int i = 0; i < 40; i++) hold($urandom % 2, 1);
    hold(1, 2);
    check(dout == 1'b0 || dout == 1'b1, "R2", dout, dout);
    hold(1, 1);
    check(dout == 1'b1, "R2 three-edge latency", dout, 1);
    hold(0, 3);
    check(dout == 1'b0, "R2 follow low", dout, 0);

    setting = 2'd1;
    cur_req = "R3";
    hold(0, 10);
    hold(1, 4);
    cur_req = "R4";
    hold(0, 8);
    check(dout == 1'b0, "R4 short pulse ignored", dout, 0);
    cur_req = "R3";
    hold(1, 15);
    check(dout == 1'b1, "R3 long high accepted", dout, 1);
    cur_req = "R5";
    hold(0, 4);
    hold(1, 3);
    check(dout == 1'b1, "R5 short low ignored", dout, 1);
    hold(0, 12);
    check(dout == 1'b0, "R5 long low accepted", dout, 0);
    cur_req = "R4";
    runs(200, 8);

    setting = 2'd2;
    cur_req = "R6";
    runs(300, 14);
    hold(1, 20);
    check(dout == 1'b1, "R6 medium accepted", dout, 1);

    setting = 2'd3;
    cur_req = "R7";
    runs(600, 40);
    hold(0, 60);
    check(dout == 1'b0, "R7 slow low", dout, 0);
    hold(1, 60);
    check(dout == 1'b1, "R7 slow high", dout, 1);

    cur_req = "R8";
    for (int i = 0; i < 150; i++) begin
      setting = $urandom % 4;
      hold($urandom % 2, 1 + ($urandom % 12));
    end

    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      bypass  = $urandom % 2;
      setting = $urandom % 4;
      hold($urandom % 2, 1);
    end
    bypass = 1'b1;
    din = 1'b1;
    #1;
    check(dout == 1'b1, "R9 raw high", dout, 1);
    din = 1'b0;
    #1;
    check(dout == 1'b0, "R9 raw low", dout, 0);
    bypass = 1'b0;
    @(negedge clk);

    cmp_on = 1'b0;
    summary();
    $finish;
  end
endmodule